// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a narrow, byte-wide register window onto a larger bank of card-interface configuration and status registers. The host first stores an internal register number in an index port, then reads or writes the chosen register through a data port. The index persists, so a sequence of data-port accesses keeps hitting the same internal register until the index is rewritten.

Behind the window sit a two-bit card clock select, a packet block-size pair (twelve size bits plus a wide-bus flag), DMA and FIFO-enable bytes, a setup register with two self-clearing reset commands and a DATA3 drive bit, a read-only status byte, and a response length flag with a sixteen-byte response array. The status byte and the response storage are filled from the card side, which is modelled here by side ports. A soft-reset command zeroes the clock, block-size, DMA and FIFO-enable registers for as long as it runs; both reset bits read back as 1 until they clear themselves, so software polls them.

Top module: `cfg_index_port`

## Requirements
- R1: A host write at offset 5 sets the 8-bit index; a read at offset 5 returns it; it keeps its value across any number of data-port (offset 6) accesses.
- R2: Index 1 is the clock select: only data bits 1:0 are stored (0 = 375 kHz, 1 = 12 MHz, 2 = 16 MHz, 3 = 24 MHz), bits 7:2 read 0, reset value 0, driven on `clk_sel`.
- R3: Index 5 stores size bits 7:0; index 2 stores size bits 11:8 in its bits 7:4 and the wide (4-bit) bus flag in bit 0, its other bits read 0; `blk_size` and `wide_bus` reflect them.
- R4: Index 6 is setup: bit 3 is a plain read/write bit driving `data3_hi`; bits 7:4 and 0 read 0.
- R5: Writing 1 to setup bit 1 (soft reset) or bit 2 (FIFO reset) sets that bit; it reads 1 for exactly RST_CYCLES clock cycles after the write edge and then reads 0; `soft_rst_act`/`fifo_rst_act` mirror the bits. A FIFO reset alone changes no other register.
- R6: While soft reset is active, clock select, index 2, index 5, DMA (index 7) and FIFO enable (index 8) are forced to 0 and data writes to them are lost.
- R7: Index 0x10 returns `card_status` as sampled at the read edge; host writes to it have no effect.
- R8: Index 0x1E returns the response length in bit 0 (0 short, 1 for 136-bit); indices 0x1F+n, n = 0..15, return response byte n as loaded through the side port; host writes to them have no effect.
- R9: Unimplemented indices and direct offsets other than 5 and 6 read 0x00, and writes to them change no register.
- R10: `host_rdata` is registered: it takes the addressed value at the edge where `host_rd` is sampled and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Direct host offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| card_status | input | 8 | Live status bits from the card side |
| rsp_ld_en | input | 1 | Load one response byte |
| rsp_ld_sel | input | RSP_SELW | Response byte number to load |
| rsp_ld_byte | input | 8 | Response byte value |
| rsp_len_ld | input | 1 | Load the response length flag |
| rsp_len_long | input | 1 | Length flag value (1 = long) |
| clk_sel | output | 2 | Card clock select code |
| blk_size | output | 12 | Packet block size |
| wide_bus | output | 1 | 4-bit bus mode flag |
| data3_hi | output | 1 | Drive DATA3 high |
| soft_rst_act | output | 1 | Soft reset in progress |
| fifo_rst_act | output | 1 | FIFO reset in progress |

## Verification
The bench reads the setup register on every cycle right after a reset command, so a self-clear that ends one cycle early or late shows as a wrong byte at a precise read; a design that forgot to hold the block-size or DMA bytes at zero during soft reset would read back the old values afterwards. Masked bits are probed with all-ones writes, so a clock or block-size register that stored the whole byte is caught. The status, response and unimplemented indices are written with data and read back, so a design that let host writes reach them, or decoded an unknown index to a neighbour, returns a non-zero or changed byte.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam logic [2:0] OFF_INDEX = 3'd5;
  localparam logic [2:0] OFF_DATA  = 3'd6;

  localparam logic [7:0] IX_CLK    = 8'h01;
  localparam logic [7:0] IX_BSZ_HI = 8'h02;
  localparam logic [7:0] IX_BSZ_LO = 8'h05;
  localparam logic [7:0] IX_SETUP  = 8'h06;
  localparam logic [7:0] IX_DMA    = 8'h07;
  localparam logic [7:0] IX_FIFOEN = 8'h08;
  localparam logic [7:0] IX_STATUS = 8'h10;
  localparam logic [7:0] IX_RSPLEN = 8'h1E;
  localparam logic [7:0] IX_RSP0   = 8'h1F;

  // setup bit positions
  localparam int SU_SOFT  = 1;
  localparam int SU_FIFO  = 2;
  localparam int SU_DATA3 = 3;

  // keep only the stored fields of the size-high byte
  function automatic logic [7:0] bsz_hi_mask(input logic [7:0] w);
    return {w[7:4], 3'b000, w[0]};
  endfunction

  // assemble the twelve-bit size from both bytes
  function automatic logic [11:0] bsz_join(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[7:4], lo};
  endfunction

  function automatic logic [7:0] setup_view(input logic d3, input logic fr, input logic sr);
    return {4'b0000, d3, fr, sr, 1'b0};
  endfunction
endpackage

// File: rtl/cip_selfclr.sv
module cip_selfclr #(
  parameter int CYC = 4,
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic active
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (!active) begin
      if (set) begin
        active <= 1'b1;
        cnt_q  <= CW'(CYC - 1);
      end
    end else if (cnt_q == '0) begin
      active <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cip_rsp_store.sv
module cip_rsp_store #(
  parameter int N = 16,
  localparam int SW = (N < 2) ? 1 : $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [7:0]    ld_byte,
  input  logic          len_ld,
  input  logic          len_val,
  input  logic [SW-1:0] rd_sel,
  output logic [7:0]    rd_byte,
  output logic          len_q
);
  logic [7:0] bytes_q [N];

  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                          bytes_q[g] <= 8'h00;
      else if (ld_en && ld_sel == SW'(g))  bytes_q[g] <= ld_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      len_q <= 1'b0;
    else if (len_ld) len_q <= len_val;
  end

  assign rd_byte = bytes_q[rd_sel];
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cip_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int RSP_BYTES  = 16,
  localparam int RSP_SELW  = (RSP_BYTES < 2) ? 1 : $clog2(RSP_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          host_addr,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  input  logic [7:0]          card_status,
  input  logic                rsp_ld_en,
  input  logic [RSP_SELW-1:0] rsp_ld_sel,
  input  logic [7:0]          rsp_ld_byte,
  input  logic                rsp_len_ld,
  input  logic                rsp_len_long,
  output logic [1:0]          clk_sel,
  output logic [11:0]         blk_size,
  output logic                wide_bus,
  output logic                data3_hi,
  output logic                soft_rst_act,
  output logic                fifo_rst_act
);
  localparam int NRST = 2;
  localparam int RST_BIT [NRST] = '{SU_SOFT, SU_FIFO};

  logic [7:0] idx_q;
  logic [1:0] clk_q;
  logic [7:0] bhi_q, blo_q, dma_q, fen_q;
  logic       d3_q;

  // named decode events
  logic wr_index, wr_data;
  logic wr_clk, wr_bhi, wr_blo, wr_setup, wr_dma, wr_fen;
  assign wr_index = host_wr && host_addr == OFF_INDEX;
  assign wr_data  = host_wr && host_addr == OFF_DATA;
  assign wr_clk   = wr_data && idx_q == IX_CLK;
  assign wr_bhi   = wr_data && idx_q == IX_BSZ_HI;
  assign wr_blo   = wr_data && idx_q == IX_BSZ_LO;
  assign wr_setup = wr_data && idx_q == IX_SETUP;
  assign wr_dma   = wr_data && idx_q == IX_DMA;
  assign wr_fen   = wr_data && idx_q == IX_FIFOEN;

  // self-clearing reset commands
  logic [NRST-1:0] rst_act;
  for (genvar g = 0; g < NRST; g++) begin : g_rst
    cip_selfclr #(.CYC(RST_CYCLES)) u_sc (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (wr_setup && host_wdata[RST_BIT[g]]),
      .active (rst_act[g])
    );
  end
  assign soft_rst_act = rst_act[0];
  assign fifo_rst_act = rst_act[1];

  // response storage
  logic [7:0]          rsp_off;
  logic                in_rsp;
  logic [7:0]          rsp_byte;
  logic                rsp_len;
  assign rsp_off = idx_q - IX_RSP0;
  assign in_rsp  = rsp_off < 8'(RSP_BYTES);

  cip_rsp_store #(.N(RSP_BYTES)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (rsp_ld_en),
    .ld_sel  (rsp_ld_sel),
    .ld_byte (rsp_ld_byte),
    .len_ld  (rsp_len_ld),
    .len_val (rsp_len_long),
    .rd_sel  (rsp_off[RSP_SELW-1:0]),
    .rd_byte (rsp_byte),
    .len_q   (rsp_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_q <= 8'h00;
    else if (wr_index) idx_q <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        d3_q <= 1'b0;
    else if (wr_setup) d3_q <= host_wdata[SU_DATA3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst_act) begin
      clk_q <= 2'd0;
      bhi_q <= 8'h00;
      blo_q <= 8'h00;
      dma_q <= 8'h00;
      fen_q <= 8'h00;
    end else begin
      if (wr_clk) clk_q <= host_wdata[1:0];
      if (wr_bhi) bhi_q <= bsz_hi_mask(host_wdata);
      if (wr_blo) blo_q <= host_wdata;
      if (wr_dma) dma_q <= host_wdata;
      if (wr_fen) fen_q <= host_wdata;
    end
  end

  // indexed read mux
  logic [7:0] ix_rd;
  always_comb begin
    ix_rd = 8'h00;
    if (in_rsp) ix_rd = rsp_byte;
    else begin
      unique case (idx_q)
        IX_CLK:    ix_rd = {6'b0, clk_q};
        IX_BSZ_HI: ix_rd = bhi_q;
        IX_BSZ_LO: ix_rd = blo_q;
        IX_SETUP:  ix_rd = setup_view(d3_q, fifo_rst_act, soft_rst_act);
        IX_DMA:    ix_rd = dma_q;
        IX_FIFOEN: ix_rd = fen_q;
        IX_STATUS: ix_rd = card_status;
        IX_RSPLEN: ix_rd = {7'b0, rsp_len};
        default:   ix_rd = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= 8'h00;
    else if (host_rd) begin
      if (host_addr == OFF_INDEX)     host_rdata <= idx_q;
      else if (host_addr == OFF_DATA) host_rdata <= ix_rd;
      else                            host_rdata <= 8'h00;
    end
  end

  assign clk_sel  = clk_q;
  assign blk_size = bsz_join(bhi_q, blo_q);
  assign wide_bus = bhi_q[0];
  assign data3_hi = d3_q;
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  host_addr,
  input logic        host_wr,
  input logic        host_rd,
  input logic [7:0]  host_rdata,
  input logic [7:0]  card_status,
  input logic [7:0]  idx_q,
  input logic [1:0]  clk_sel,
  input logic [11:0] blk_size,
  input logic        wide_bus,
  input logic        soft_rst_act,
  input logic        fifo_rst_act
);
  logic [15:0] sr_cnt, fr_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_cnt <= '0;
      fr_cnt <= '0;
    end else begin
      sr_cnt <= soft_rst_act ? sr_cnt + 1'b1 : 16'd0;
      fr_cnt <= fifo_rst_act ? fr_cnt + 1'b1 : 16'd0;
    end
  end

  a_r5_soft_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_act) |-> sr_cnt == 16'(RST_CYCLES));
  a_r5_fifo_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_rst_act) |-> fr_cnt == 16'(RST_CYCLES));
  a_r5_soft_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_act |-> sr_cnt < 16'(RST_CYCLES));
  a_r6_regs_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst_act) |-> (clk_sel == 2'd0 && blk_size == 12'd0 && !wide_bus));
  a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == 3'd5) |=> $stable(idx_q));
  a_r2_clk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(host_wr && host_addr == 3'd6 && idx_q == 8'h01) && !soft_rst_act) |=> $stable(clk_sel));
  a_r7_status_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd6 && idx_q == 8'h10) |=> host_rdata == $past(card_status));
  a_r9_other_offsets: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr != 3'd5 && host_addr != 3'd6) |=> host_rdata == 8'h00);
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
endmodule

bind cfg_index_port cfg_index_port_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_addr    (host_addr),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_rdata   (host_rdata),
  .card_status  (card_status),
  .idx_q        (idx_q),
  .clk_sel      (clk_sel),
  .blk_size     (blk_size),
  .wide_bus     (wide_bus),
  .soft_rst_act (soft_rst_act),
  .fifo_rst_act (fifo_rst_act)
);

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
  localparam int CYC = 4;
  localparam int NB  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [7:0] card_status = '0;
  logic       rsp_ld_en = 1'b0;
  logic [3:0] rsp_ld_sel = '0;
  logic [7:0] rsp_ld_byte = '0;
  logic       rsp_len_ld = 1'b0, rsp_len_long = 1'b0;
  logic [1:0] clk_sel;
  logic [11:0] blk_size;
  logic       wide_bus, data3_hi, soft_rst_act, fifo_rst_act;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_index_port #(.RST_CYCLES(CYC), .RSP_BYTES(NB)) u_cfg_index_port (
    .clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .card_status, .rsp_ld_en, .rsp_ld_sel, .rsp_ld_byte, .rsp_len_ld, .rsp_len_long,
    .clk_sel, .blk_size, .wide_bus, .data3_hi, .soft_rst_act, .fifo_rst_act
  );

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always @(posedge clk) pend <= host_rd;

  always @(negedge clk) begin
    if (pend) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL %s: read with no expected item, actual %02h expected none", "R10", host_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (host_rdata !== e) begin
          nfail++;
          $display("FAIL %s: actual %02h expected %02h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic hw(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, input logic [7:0] e, input string t);
    host_addr = a; host_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic ixw(input logic [7:0] ix, input logic [7:0] d);
    hw(3'd5, ix); hw(3'd6, d);
  endtask

  task automatic ixr(input logic [7:0] ix, input logic [7:0] e, input string t);
    hw(3'd5, ix); hr(3'd6, e, t);
  endtask

  task automatic chk(input string t, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R4 reset state
    chk("R2 reset clk_sel", clk_sel, 0);
    chk("R3 reset blk_size", blk_size, 0);
    chk("R4 reset data3_hi", data3_hi, 0);
    hr(3'd5, 8'h00, "R1 reset index");
    hr(3'd6, 8'h00, "R9 index 0 unimplemented");

    // R1 R2 clock select, repeated access
    ixw(8'h01, 8'h03);
    hr(3'd6, 8'h03, "R2 clk code 3");
    hr(3'd6, 8'h03, "R1 repeated data read");
    hr(3'd5, 8'h01, "R1 index retained");
    chk("R2 clk_sel port", clk_sel, 3);
    hw(3'd6, 8'hFE);
    hr(3'd6, 8'h02, "R2 upper bits masked");
    chk("R2 clk_sel 16M", clk_sel, 2);

    // R3 block size
    ixw(8'h02, 8'hA5);
    ixw(8'h05, 8'h3C);
    chk("R3 blk_size", blk_size, 12'hA3C);
    chk("R3 wide_bus", wide_bus, 1);
    hr(3'd6, 8'h3C, "R3 low byte");
    ixr(8'h02, 8'hA1, "R3 high byte masked");
    ixw(8'h07, 8'h55);
    ixw(8'h08, 8'h18);
    ixr(8'h07, 8'h55, "R6 dma readback");
    ixr(8'h08, 8'h18, "R6 fifo enable readback");

    // R4 data3
    ixw(8'h06, 8'h08);
    chk("R4 data3_hi set", data3_hi, 1);
    hr(3'd6, 8'h08, "R4 setup readback");

    // R5 R6 soft reset, polled every cycle
    hw(3'd6, 8'h0A);
    for (int i = 0; i < CYC; i++) hr(3'd6, 8'h0A, "R5 soft bit still set");
    hr(3'd6, 8'h08, "R5 soft bit cleared");
    chk("R6 clk_sel zeroed", clk_sel, 0);
    chk("R6 blk_size zeroed", blk_size, 0);
    chk("R6 wide_bus zeroed", wide_bus, 0);
    chk("R4 data3 kept", data3_hi, 1);
    ixr(8'h01, 8'h00, "R6 clk reg zero");
    ixr(8'h02, 8'h00, "R6 size high zero");
    ixr(8'h05, 8'h00, "R6 size low zero");
    ixr(8'h07, 8'h00, "R6 dma zero");
    ixr(8'h08, 8'h00, "R6 fifo enable zero");

    // R6 writes during soft reset are lost
    ixw(8'h06, 8'h02);
    ixw(8'h01, 8'h03);
    repeat (CYC + 1) @(negedge clk);
    chk("R6 write lost in reset", clk_sel, 0);

    // R5 FIFO reset leaves other regs alone
    ixw(8'h01, 8'h02);
    ixw(8'h06, 8'h0C);
    for (int i = 0; i < CYC; i++) hr(3'd6, 8'h0C, "R5 fifo bit still set");
    hr(3'd6, 8'h08, "R5 fifo bit cleared");
    chk("R5 fifo reset keeps clk", clk_sel, 2);

    // R7 status
    card_status = 8'hA5;
    ixr(8'h10, 8'hA5, "R7 status A5");
    hw(3'd6, 8'h00);
    card_status = 8'h81;
    hr(3'd6, 8'h81, "R7 status after write");

    // R8 response
    for (int n = 0; n < NB; n++) begin
      rsp_ld_en = 1'b1; rsp_ld_sel = 4'(n); rsp_ld_byte = 8'(n * 17 + 3);
      @(negedge clk);
    end
    rsp_ld_en = 1'b0;
    rsp_len_ld = 1'b1; rsp_len_long = 1'b1;
    @(negedge clk);
    rsp_len_ld = 1'b0;
    ixr(8'h1E, 8'h01, "R8 long length");
    ixr(8'h1F, 8'h03, "R8 byte 0");
    for (int n = 12; n < NB; n++) ixr(8'(8'h1F + n), 8'(n * 17 + 3), "R8 short bytes");
    ixw(8'h20, 8'h00);
    hr(3'd6, 8'h14, "R8 host write ignored");
    rsp_len_ld = 1'b1; rsp_len_long = 1'b0;
    @(negedge clk);
    rsp_len_ld = 1'b0;
    ixr(8'h1E, 8'h00, "R8 short length");

    // R9 unimplemented
    ixw(8'h30, 8'hFF);
    hr(3'd6, 8'h00, "R9 index 30");
    ixw(8'h03, 8'hFF);
    hr(3'd6, 8'h00, "R9 index 3");
    ixr(8'h2F, 8'h00, "R9 past response array");
    hw(3'd0, 8'h01);
    hw(3'd7, 8'h03);
    hr(3'd5, 8'h2F, "R9 stray writes leave index");
    chk("R9 stray writes leave clk", clk_sel, 2);
    hr(3'd0, 8'h00, "R9 offset 0 reads zero");
    hr(3'd7, 8'h00, "R9 offset 7 reads zero");

    // R10 hold
    hw(3'd5, 8'h01);
    hr(3'd6, 8'h02, "R10 read clk");
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", host_rdata, 8'h02);

    repeat (2) @(negedge clk);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule